// File: doc/BRIEF.md
# SCSI Byte-Lane Parity Generator and Checker

This block sits between the data path of a 16-bit parallel SCSI-style bus and the control logic that owns it. Each byte lane of the bus carries its own parity line. On the sending side the block produces one parity bit per lane. Normally that bit makes the lane odd. A test control flips it to even parity, so that a receiver's error handling can be exercised on purpose.

On the receiving side the block checks each lane against odd parity whenever a receive strobe is asserted and checking is enabled. A mismatch on either lane raises a single sticky receive error flag. The block also keeps odd parity latched for every captured word, one bit per lane, and shows the live level of each parity line.

A second sticky status bit records a parity error that a target reports while this device is master in a data phase. That bit is gated by its own enable. Each status bit can be masked from a registered interrupt output on its own.

Top module: `scsi_lane_parity`

## Requirements
- R1: With `cfg_send_even` low, `tx_par[i]` makes lane i of `tx_data` plus its parity bit hold an odd number of ones, whatever the value of `cfg_check_en`. Lane i is bits [8i+7:8i], and `tx_par[i]` belongs to lane i.
- R2: With `cfg_send_even` high, `tx_par[i]` makes lane i plus its parity bit hold an even number of ones.
- R3: While `cfg_check_en` is low, a receive strobe never sets `rx_perr`.
- R4: On a clock edge where `rx_strobe` and `cfg_check_en` are both high, `rx_perr` is set from the next cycle on if any lane of `rx_data` together with its `rx_par` bit holds an even number of ones. The check always expects odd parity and ignores `cfg_send_even`. Without a strobe, nothing is checked.
- R5: `par_level[i]` shows the present active-high level of `rx_par[i]`.
- R6: On each edge with `rx_strobe` high, `latch_par[i]` takes the odd parity bit of lane i of `rx_data`. It holds that value between strobes.
- R7: `mdpe` is set in the cycle after an edge where `is_master`, `data_phase`, `tgt_perr` and `cfg_mstr_chk_en` are all high. If any of them is low, `mdpe` is not set.
- R8: `rx_perr` and `mdpe` are sticky. A `status_clr` pulse clears them. When a clear and a new error meet on the same edge, the bit stays set.
- R9: `irq` is registered as (`rx_perr` AND `cfg_irq_en_rx`) OR (`mdpe` AND `cfg_irq_en_mdpe`), one clock after the status. A masked status bit still sets, but `irq` stays low.
- R10: While `rst_n` is low, `rx_perr`, `mdpe`, `irq` and `latch_par` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_data | input | 16 | Outgoing data word |
| tx_par | output | 2 | Generated parity, one bit per lane |
| rx_data | input | 16 | Incoming data word |
| rx_par | input | 2 | Incoming parity lines |
| rx_strobe | input | 1 | Capture and check the incoming word |
| par_level | output | 2 | Live level of the parity lines |
| latch_par | output | 2 | Odd parity of the last captured word |
| cfg_check_en | input | 1 | Enable receive parity checking |
| cfg_send_even | input | 1 | Send even parity instead of odd |
| cfg_mstr_chk_en | input | 1 | Enable master data-phase error capture |
| cfg_irq_en_rx | input | 1 | Let the receive error drive irq |
| cfg_irq_en_mdpe | input | 1 | Let the master error drive irq |
| is_master | input | 1 | Device is bus master |
| data_phase | input | 1 | Bus is in a data phase |
| tgt_perr | input | 1 | Target signals a parity error |
| status_clr | input | 1 | Clear both status bits |
| rx_perr | output | 1 | Sticky receive parity error |
| mdpe | output | 1 | Sticky master data parity error |
| irq | output | 1 | Registered masked interrupt |

## Verification
The sending side is tried with a table of words holding zero, odd and even numbers of ones per lane. Each word is tried with both polarity settings and with checking on and off. This tells lane order apart, and it shows that the checking control has no effect on what is sent. On the receiving side, single bad lanes (low, then high), good words, and bad words with no strobe are applied. This separates per-lane detection from strobe qualification. The same words are then applied with even send polarity or with checking off, to show that the checker's expectation is fixed. Directed runs cover each master qualifier alone, a clear on the same edge as a new error, and the interrupt's one-cycle lag and its masking.

// File: rtl/scsi_lane_parity.sv
module scsi_lane_parity #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES*LANE_W-1:0] tx_data,
  output logic [LANES-1:0]        tx_par,
  input  logic [LANES*LANE_W-1:0] rx_data,
  input  logic [LANES-1:0]        rx_par,
  input  logic                    rx_strobe,
  output logic [LANES-1:0]        par_level,
  output logic [LANES-1:0]        latch_par,
  input  logic                    cfg_check_en,
  input  logic                    cfg_send_even,
  input  logic                    cfg_mstr_chk_en,
  input  logic                    cfg_irq_en_rx,
  input  logic                    cfg_irq_en_mdpe,
  input  logic                    is_master,
  input  logic                    data_phase,
  input  logic                    tgt_perr,
  input  logic                    status_clr,
  output logic                    rx_perr,
  output logic                    mdpe,
  output logic                    irq
);
  logic [LANES-1:0] tx_odd, rx_odd, lane_bad;
  logic             rx_hit, mdpe_hit;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign tx_odd[i] = ~^tx_data[i*LANE_W +: LANE_W];
    assign rx_odd[i] = ~^rx_data[i*LANE_W +: LANE_W];
  end

  assign tx_par    = cfg_send_even ? ~tx_odd : tx_odd;
  assign par_level = rx_par;
  assign lane_bad  = rx_par ^ rx_odd;
  assign rx_hit    = rx_strobe & cfg_check_en & (|lane_bad);
  assign mdpe_hit  = is_master & data_phase & tgt_perr & cfg_mstr_chk_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_par <= '0;
      rx_perr   <= 1'b0;
      mdpe      <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (rx_strobe) latch_par <= rx_odd;
      rx_perr <= rx_hit   | (rx_perr & ~status_clr);
      mdpe    <= mdpe_hit | (mdpe    & ~status_clr);
      irq     <= (rx_perr & cfg_irq_en_rx) | (mdpe & cfg_irq_en_mdpe);
    end
  end
endmodule

// File: rtl/scsi_lane_parity_chk.sv
module scsi_lane_parity_chk #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [LANES*LANE_W-1:0] tx_data,
  input logic [LANES-1:0]        tx_par,
  input logic [LANES*LANE_W-1:0] rx_data,
  input logic                    rx_strobe,
  input logic [LANES-1:0]        latch_par,
  input logic                    cfg_check_en,
  input logic                    cfg_send_even,
  input logic                    cfg_mstr_chk_en,
  input logic                    cfg_irq_en_rx,
  input logic                    cfg_irq_en_mdpe,
  input logic                    is_master,
  input logic                    data_phase,
  input logic                    tgt_perr,
  input logic                    status_clr,
  input logic                    rx_perr,
  input logic                    mdpe,
  input logic                    irq
);
  for (genvar i = 0; i < LANES; i++) begin : g_chk
    p_tx_odd_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_send_even |-> (^{tx_par[i], tx_data[i*LANE_W +: LANE_W]}) == 1'b1);
    p_tx_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_send_even |-> (^{tx_par[i], tx_data[i*LANE_W +: LANE_W]}) == 1'b0);
    p_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_strobe |=> latch_par[i] == ~^$past(rx_data[i*LANE_W +: LANE_W]));
  end

  p_quiet_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_check_en && !rx_perr) |=> !rx_perr);
  p_no_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_strobe && !rx_perr) |=> !rx_perr);
  p_mdpe_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && data_phase && tgt_perr && cfg_mstr_chk_en) |=> mdpe);
  p_mdpe_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mstr_chk_en && !mdpe) |=> !mdpe);
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_perr && !status_clr) |=> rx_perr);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (status_clr && !is_master) |=> !mdpe);
  p_irq_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_irq_en_rx && !cfg_irq_en_mdpe) |=> !irq);
  p_irq_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_perr && cfg_irq_en_rx) |=> irq);
endmodule

bind scsi_lane_parity scsi_lane_parity_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/scsi_lane_parity_test.sv
module scsi_lane_parity_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] tx_data = '0, rx_data = '0;
  logic [1:0] tx_par, rx_par = '0, par_level, latch_par;
  logic rx_strobe = 0, cfg_check_en = 0, cfg_send_even = 0, cfg_mstr_chk_en = 0;
  logic cfg_irq_en_rx = 0, cfg_irq_en_mdpe = 0, is_master = 0, data_phase = 0;
  logic tgt_perr = 0, status_clr = 0, rx_perr, mdpe, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scsi_lane_parity uut (.*);

  // {data, send_even, check_en, expected tx_par {hi,lo}}
  localparam logic [19:0] VEC [9] = '{
    {16'h0000, 1'b0, 1'b0, 2'b11}, {16'h0000, 1'b1, 1'b1, 2'b00},
    {16'h0100, 1'b0, 1'b1, 2'b01}, {16'h0100, 1'b1, 1'b0, 2'b10},
    {16'hFF7F, 1'b0, 1'b1, 2'b10}, {16'hFF7F, 1'b1, 1'b1, 2'b01},
    {16'h8001, 1'b0, 1'b0, 2'b00}, {16'h8001, 1'b1, 1'b0, 2'b11},
    {16'hA5C3, 1'b0, 1'b1, 2'b11}};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic pulse_rx(input logic [15:0] d, input logic [1:0] p);
    rx_data = d; rx_par = p; rx_strobe = 1;
    step();
    rx_strobe = 0;
  endtask

  task automatic clear();
    status_clr = 1; step(); status_clr = 0; step();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual expired expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    step(); step(); step();
    check("R10 rx_perr", rx_perr, 0);
    check("R10 mdpe", mdpe, 0);
    check("R10 irq", irq, 0);
    check("R10 latch_par", latch_par, 0);
    rst_n = 1;
    step();

    foreach (VEC[k]) begin
      tx_data = VEC[k][19:4]; cfg_send_even = VEC[k][3]; cfg_check_en = VEC[k][2];
      #2;
      check(VEC[k][3] ? "R2 even tx parity" : "R1 odd tx parity", tx_par, VEC[k][1:0]);
      step();
    end

    cfg_send_even = 0; cfg_check_en = 1;
    pulse_rx(16'h0000, 2'b11);
    check("R4 good word", rx_perr, 0);
    check("R6 latch zero word", latch_par, 2'b11);
    pulse_rx(16'hFF7F, 2'b10);
    check("R4 good word 2", rx_perr, 0);
    check("R6 latch FF7F", latch_par, 2'b10);
    rx_data = 16'h0000; rx_par = 2'b10; step(); step();
    check("R4 no strobe", rx_perr, 0);
    check("R6 latch hold", latch_par, 2'b10);
    pulse_rx(16'h0000, 2'b10);
    check("R4 low lane bad", rx_perr, 1);
    step(); step();
    check("R8 sticky", rx_perr, 1);
    clear();
    check("R8 cleared", rx_perr, 0);
    pulse_rx(16'h0000, 2'b01);
    check("R4 high lane bad", rx_perr, 1);
    clear();
    cfg_send_even = 1;
    pulse_rx(16'h0000, 2'b11);
    check("R4 odd expected under send_even", rx_perr, 0);
    pulse_rx(16'h0000, 2'b00);
    check("R4 even word flagged under send_even", rx_perr, 1);
    clear();
    cfg_send_even = 0; cfg_check_en = 0;
    pulse_rx(16'h0000, 2'b00);
    check("R3 checking off", rx_perr, 0);
    cfg_check_en = 1;
    pulse_rx(16'h0000, 2'b00);
    rx_strobe = 1; status_clr = 1; step();
    rx_strobe = 0; status_clr = 0;
    check("R8 clear meets new error", rx_perr, 1);
    clear();
    check("R8 cleared again", rx_perr, 0);

    rx_par = 2'b10; #1;
    check("R5 level 10", par_level, 2'b10);
    rx_par = 2'b01; #1;
    check("R5 level 01", par_level, 2'b01);
    step();

    is_master = 1; data_phase = 1; tgt_perr = 1; cfg_mstr_chk_en = 0; step();
    check("R7 gated by master enable", mdpe, 0);
    cfg_mstr_chk_en = 1; data_phase = 0; step();
    check("R7 needs data phase", mdpe, 0);
    data_phase = 1; is_master = 0; step();
    check("R7 needs master", mdpe, 0);
    is_master = 1; tgt_perr = 0; step();
    check("R7 needs target error", mdpe, 0);
    tgt_perr = 1; step();
    tgt_perr = 0;
    check("R7 mdpe set", mdpe, 1);
    step(); step();
    check("R9 masked irq", irq, 0);
    check("R9 status still set", mdpe, 1);
    cfg_irq_en_mdpe = 1; step();
    check("R9 irq raised", irq, 1);
    status_clr = 1; step(); status_clr = 0;
    check("R8 mdpe cleared", mdpe, 0);
    check("R9 irq lags one cycle", irq, 1);
    step();
    check("R9 irq dropped", irq, 0);
    is_master = 0; data_phase = 0; cfg_irq_en_mdpe = 0;

    cfg_irq_en_rx = 1;
    pulse_rx(16'h0000, 2'b10);
    check("R9 rx irq not yet", irq, 0);
    step();
    check("R9 rx irq raised", irq, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule